// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block gathers up to 32 interrupt inputs and drives two active-low request lines toward a processor. One line carries normal interrupts and the other carries fast interrupts. Each input has its own trigger type, a priority from 0 to 7 and a 32-bit vector word. Input 0 belongs to the fast line only. Inputs 1 to 31 compete for the normal line. The winner is the enabled, pending input with the highest priority. If two inputs share that priority, the lower input number wins.

Software reads the vector register to get the handler address of the winning input. In normal mode, that read also acknowledges the interrupt. The acknowledge pushes the winner's priority onto an internal level stack and clears its latched edge. While a level is in service, only a strictly higher priority raises the normal line again, so handlers can nest. A write to the end-of-service register pops the stack.

Protect mode makes vector reads free of side effects, so a debugger can inspect the register safely. In that mode, a write to the vector register performs the acknowledge instead. Any normal input can be forced onto the fast line. A global mask silences both lines without touching pending state.

Top module: `vpic`

## Requirements
- R1: After reset, both request lines are high and every input is disabled. The stack depth is 0, protect and mask are off, and the force set is empty. Every input's configuration word reads 0x10 (high level, priority 0).
- R2: In a configuration word, bits [2:0] hold the priority and bits [5:4] hold the trigger. The trigger codes are: 00 low level, 01 high level, 10 falling edge, 11 rising edge. A level input is pending exactly while its input is at the active level. An edge input stays pending from the edge until it is acknowledged or cleared.
- R3: Input 0, when pending and enabled, pulls the fast line low one cycle later. It never takes part in the normal line or in the vector read.
- R4: The normal line goes low one cycle after some enabled, non-forced input in 1..31 is pending with priority above the current service level. The current level is the stack top; with an empty stack, any priority counts. Otherwise the normal line is high.
- R5: A vector read returns the vector word of the winner: highest priority first, then lowest input number. If no input qualifies under R4, the read returns the spurious vector.
- R6: A vector read with protect off and a winner present does three things. It pushes the winner's priority, increments the depth and clears the winner's edge-pending bit. A level input stays pending.
- R7: While a level is in service, an input of equal or lower priority does not raise the normal line. A strictly higher one does. An end-of-service write pops one level, and does nothing when the stack is empty.
- R8: With protect on (control bit 0), a vector read changes no state. A write to the vector register performs the R6 acknowledge instead.
- R9: A set bit i (i ≥ 1) in the force register moves input i from the normal path to the fast line. Bit 0 of that register is ignored.
- R10: Control bit 1 holds both lines high one cycle later. It leaves the pending status unchanged.
- R11: Writing ones to enable-set, enable-clear or pending-clear sets enables, clears enables or clears edge-pending bits. Zero bits leave the matching state unchanged.
- R12: Word addresses are as follows. 0–31 hold the configuration words and 32–63 hold the vector words. 64 is the vector register and 65 is enable-set. 66 is enable-clear and 67 is pending-clear. 68 is end-of-service and 69 is the spurious vector. 70 is control and 71 is force. 72 reads pending status, 73 reads enables and 74 reads the stack depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | NSRC | Interrupt inputs, synchronous to clk |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (matters only for the vector register) |
| bus_addr | input | AW | Word address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational from address |
| irq_n | output | 1 | Normal interrupt request, active low |
| fiq_n | output | 1 | Fast interrupt request, active low |

## Verification
Directed patterns cover the main distinctions:
- Two inputs of equal priority separate the tie rule from plain index order.
- An edge input and a level input of the same priority show that acknowledge clears only latched edges.
- A higher-priority falling edge during service separates true nesting from a single-level design.
- Repeated vector reads under protect tell a side-effect-free read from an acknowledging one.

A long random phase then varies triggers, priorities, enables, the force set, the mask and protect. It interleaves input toggles with reads, acknowledges and end-of-service writes, and compares both lines, the vector, the pending status and the depth against a model. This exposes errors in stack ordering and in the tie and spurious choices.

// File: rtl/vpic.sv
`timescale 1ns/1ps
module vpic #(
  parameter int NSRC = 32,
  parameter int NPRI = 8,
  parameter int AW   = 7,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_src,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            irq_n,
  output logic            fiq_n
);
  localparam int SW = $clog2(NSRC);
  localparam int LW = $clog2(NPRI);
  localparam logic [AW-1:0] A_VEC0 = AW'(NSRC);
  localparam logic [AW-1:0] A_IVR  = AW'(2*NSRC);
  localparam logic [AW-1:0] A_ENS  = AW'(2*NSRC+1);
  localparam logic [AW-1:0] A_ENC  = AW'(2*NSRC+2);
  localparam logic [AW-1:0] A_PCLR = AW'(2*NSRC+3);
  localparam logic [AW-1:0] A_EOI  = AW'(2*NSRC+4);
  localparam logic [AW-1:0] A_SPUR = AW'(2*NSRC+5);
  localparam logic [AW-1:0] A_CTRL = AW'(2*NSRC+6);
  localparam logic [AW-1:0] A_FRC  = AW'(2*NSRC+7);
  localparam logic [AW-1:0] A_PEND = AW'(2*NSRC+8);
  localparam logic [AW-1:0] A_EN   = AW'(2*NSRC+9);
  localparam logic [AW-1:0] A_DEP  = AW'(2*NSRC+10);

  logic [NSRC-1:0] src_q, pend_e, pend, hit, en, frc;
  logic            protect, gmask;
  logic [DW-1:0]   spur;
  logic [LW-1:0]   prio [NSRC];
  logic [1:0]      mode [NSRC];
  logic [DW-1:0]   vec  [NSRC];
  logic [LW-1:0]   stk  [NPRI];
  logic [LW:0]     depth;
  logic [LW-1:0]   top_idx, cur_lvl, best_p;
  logic [SW-1:0]   best_i, cfg_sel, vec_sel;
  logic            found, beats, go, rd_ivr, wr_ivr, eoi, clr_w, fiq_want;

  assign rd_ivr  = bus_rd && bus_addr == A_IVR;
  assign wr_ivr  = bus_wr && bus_addr == A_IVR;
  assign eoi     = bus_wr && bus_addr == A_EOI;
  assign clr_w   = bus_wr && bus_addr == A_PCLR;
  assign cfg_sel = SW'(bus_addr);
  assign vec_sel = SW'(bus_addr - A_VEC0);
  assign top_idx = LW'(depth - 1'b1);
  assign cur_lvl = stk[top_idx];

  always_comb begin
    for (int i = 0; i < NSRC; i++) begin
      pend[i] = mode[i][1] ? pend_e[i] : (mode[i][0] ? irq_src[i] : !irq_src[i]);
      hit[i]  = mode[i][0] ? (irq_src[i] && !src_q[i]) : (!irq_src[i] && src_q[i]);
    end
  end

  always_comb begin
    found  = 1'b0;
    best_i = '0;
    best_p = '0;
    for (int i = NSRC-1; i >= 1; i--)
      if (pend[i] && en[i] && !frc[i] && (!found || prio[i] >= best_p)) begin
        found  = 1'b1;
        best_i = SW'(i);
        best_p = prio[i];
      end
  end

  assign beats    = found && (depth == '0 || best_p > cur_lvl);
  assign go       = beats && (protect ? wr_ivr : rd_ivr);
  assign fiq_want = |(pend & en & (frc | NSRC'(1)));

  always_comb begin
    bus_rdata = '0;
    if (bus_addr < A_VEC0) begin
      bus_rdata[LW-1:0] = prio[cfg_sel];
      bus_rdata[5:4]    = mode[cfg_sel];
    end else if (bus_addr < A_IVR) bus_rdata = vec[vec_sel];
    else case (bus_addr)
      A_IVR:  bus_rdata = beats ? vec[best_i] : spur;
      A_SPUR: bus_rdata = spur;
      A_CTRL: bus_rdata = DW'({gmask, protect});
      A_FRC:  bus_rdata = DW'(frc);
      A_PEND: bus_rdata = DW'(pend);
      A_EN:   bus_rdata = DW'(en);
      A_DEP:  bus_rdata = DW'(depth);
      default: bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0; pend_e <= '0; en <= '0; frc <= '0;
      protect <= 1'b0; gmask <= 1'b0; spur <= '0;
      irq_n <= 1'b1; fiq_n <= 1'b1; depth <= '0;
      for (int i = 0; i < NSRC; i++) begin
        prio[i] <= '0; mode[i] <= 2'b01; vec[i] <= '0;
      end
      for (int k = 0; k < NPRI; k++) stk[k] <= '0;
    end else begin
      src_q <= irq_src;
      irq_n <= !(beats && !gmask);
      fiq_n <= !(fiq_want && !gmask);
      for (int i = 0; i < NSRC; i++)
        pend_e[i] <= mode[i][1] && (hit[i] ||
                     (pend_e[i] && !(clr_w && bus_wdata[i]) && !(go && best_i == SW'(i))));
      if (go) begin
        stk[depth[LW-1:0]] <= best_p;
        depth <= depth + 1'b1;
      end else if (eoi && depth != '0) depth <= depth - 1'b1;
      if (bus_wr) begin
        if (bus_addr < A_VEC0) begin
          prio[cfg_sel] <= bus_wdata[LW-1:0];
          mode[cfg_sel] <= bus_wdata[5:4];
        end else if (bus_addr < A_IVR) vec[vec_sel] <= bus_wdata;
        else case (bus_addr)
          A_ENS:  en <= en | bus_wdata[NSRC-1:0];
          A_ENC:  en <= en & ~bus_wdata[NSRC-1:0];
          A_SPUR: spur <= bus_wdata;
          A_CTRL: begin protect <= bus_wdata[0]; gmask <= bus_wdata[1]; end
          A_FRC:  frc <= bus_wdata[NSRC-1:0] & ~NSRC'(1);
          default: ;
        endcase
      end
    end
  end

  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    gmask |=> (irq_n && fiq_n)); // R10
  AST_FAST_SRC0: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[0] && en[0] && !gmask) |=> !fiq_n); // R3
  AST_DEPTH_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= (LW+1)'(NPRI)); // R7
  AST_NEST_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (go && depth != '0) |=> stk[top_idx] > $past(cur_lvl)); // R7
  AST_PROTECT_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (protect && rd_ivr && !wr_ivr && !eoi) |=> $stable(depth)); // R8
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (go && mode[best_i][1] && !hit[best_i]) |=> !pend_e[$past(best_i)]); // R6
endmodule

// File: tb/vpic_test.sv
`timescale 1ns/1ps
module vpic_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [31:0] irq_src = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_n, fiq_n;
  int checks = 0, errors = 0;

  logic [31:0] m_src = '0, m_pe = '0, m_en = '0, m_frc = '0, m_spur = '0;
  logic        m_prot = 1'b0, m_gm = 1'b0;
  logic [2:0]  m_pr [32];
  logic [1:0]  m_md [32];
  logic [31:0] m_vec [32];
  logic [2:0]  m_stk [8];
  int          m_dep = 0;

  vpic uut (.clk(clk), .rst_n(rst_n), .irq_src(irq_src), .bus_wr(bus_wr), .bus_rd(bus_rd),
            .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
            .irq_n(irq_n), .fiq_n(fiq_n));

  always #5 clk = ~clk;

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] f_pend();
    logic [31:0] p;
    for (int i = 0; i < 32; i++)
      p[i] = m_md[i][1] ? m_pe[i] : (m_md[i][0] ? m_src[i] : !m_src[i]);
    return p;
  endfunction

  function automatic int f_best();
    logic [31:0] p = f_pend();
    int b = -1;
    for (int i = 31; i >= 1; i--)
      if (p[i] && m_en[i] && !m_frc[i] && (b < 0 || m_pr[i] >= m_pr[b])) b = i;
    if (b >= 0 && m_dep > 0 && m_pr[b] <= m_stk[m_dep-1]) b = -1;
    return b;
  endfunction

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 7'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 7'(a);
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic ack(int b);
    m_stk[m_dep] = m_pr[b];
    m_dep++;
    if (m_md[b][1]) m_pe[b] = 1'b0;
  endtask

  task automatic set_src(logic [31:0] v);
    @(negedge clk);
    for (int i = 0; i < 32; i++)
      if (m_md[i][1] && (m_md[i][0] ? (v[i] && !m_src[i]) : (!v[i] && m_src[i]))) m_pe[i] = 1'b1;
    m_src = v; irq_src = v;
  endtask

  task automatic cfg(int i, logic [2:0] p, logic [1:0] md, logic [31:0] v);
    wr(i, (32'(md) << 4) | 32'(p));
    wr(32 + i, v);
    m_pr[i] = p; m_md[i] = md; m_vec[i] = v;
    if (!md[1]) m_pe[i] = 1'b0;
  endtask

  task automatic ivr_read(string req);
    logic [31:0] d;
    int b = f_best();
    rd(64, d);
    check(req, d, b >= 0 ? m_vec[b] : m_spur);
    if (!m_prot && b >= 0) ack(b);
  endtask

  task automatic ivr_write();
    int b = f_best();
    wr(64, 0);
    if (m_prot && b >= 0) ack(b);
  endtask

  task automatic eoi();
    wr(68, 0);
    if (m_dep > 0) m_dep--;
  endtask

  task automatic lines(string req);
    logic [31:0] p;
    repeat (3) @(negedge clk);
    p = f_pend();
    check({req, " irq_n"}, 32'(irq_n), 32'(!(f_best() >= 0 && !m_gm)));
    check({req, " fiq_n"}, 32'(fiq_n), 32'(!((|(p & m_en & (m_frc | 32'd1))) && !m_gm)));
  endtask

  task automatic chk_state(string req);
    logic [31:0] d;
    rd(72, d); check({req, " pend"}, d, f_pend());
    rd(74, d); check({req, " depth"}, d, 32'(m_dep));
  endtask

  task automatic set_en(logic [31:0] s, logic [31:0] c);
    wr(65, s); wr(66, c);
    m_en = (m_en | s) & ~c;
  endtask

  initial begin
    logic [31:0] d, snap;
    void'($urandom(32'd4242));
    for (int i = 0; i < 32; i++) begin
      m_pr[i] = 3'd0; m_md[i] = 2'b01; m_vec[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq_n", 32'(irq_n), 32'd1);
    check("R1 fiq_n", 32'(fiq_n), 32'd1);
    rd(73, d); check("R1 enables", d, 32'd0);
    rd(74, d); check("R1 depth", d, 32'd0);
    rd(70, d); check("R1 control", d, 32'd0);
    rd(71, d); check("R1 force", d, 32'd0);
    rd(5, d);  check("R1 R12 cfg word", d, 32'h10);

    wr(69, 32'hDEAD_0000); m_spur = 32'hDEAD_0000;
    ivr_read("R5 spurious when idle");
    cfg(3, 3'd5, 2'b01, 32'hA000_0003);
    cfg(7, 3'd5, 2'b11, 32'hA000_0007);
    cfg(9, 3'd6, 2'b10, 32'hA000_0009);
    rd(39, d); check("R12 vector readback", d, 32'hA000_0007);
    set_en(32'h0000_0288, 32'h0);
    lines("R4 idle lines");
    set_src(32'h0000_0088);
    lines("R2 R4 level and edge pending");
    rd(64, d); check("R5 tie lower index", d, 32'hA000_0003);
    ack(3);
    lines("R7 equal priority held off");
    chk_state("R6 level stays pending");
    set_src(32'h0000_0288);
    set_src(32'h0000_0088);
    lines("R7 higher priority nests");
    ivr_read("R7 nested vector");
    chk_state("R6 edge cleared on ack");
    eoi(); eoi(); eoi();
    chk_state("R7 pop to empty");
    lines("R7 after pops");

    wr(70, 32'd1); m_prot = 1'b1;
    ivr_read("R8 protect read one");
    ivr_read("R8 protect read two");
    chk_state("R8 no side effect");
    ivr_write();
    chk_state("R8 write acknowledges");
    eoi();
    wr(70, 32'd0); m_prot = 1'b0;

    wr(71, 32'h0000_0081); m_frc = 32'h0000_0080;
    rd(71, d); check("R9 bit0 ignored", d, 32'h0000_0080);
    lines("R9 forced to fast");
    ivr_read("R9 forced excluded");
    eoi();
    wr(71, 32'h0); m_frc = '0;

    cfg(0, 3'd7, 2'b01, 32'hA000_0000);
    set_en(32'h1, 32'h0);
    set_src(32'h0000_0089);
    lines("R3 source 0 fast only");
    ivr_read("R3 source 0 not vectored");
    eoi();

    rd(72, snap);
    wr(70, 32'd2); m_gm = 1'b1;
    lines("R10 mask quiet");
    rd(72, d); check("R10 pending kept", d, snap);
    wr(70, 32'd0); m_gm = 1'b0;
    lines("R10 mask released");

    wr(67, 32'h0000_0088); m_pe[7] = 1'b0;
    chk_state("R11 pending clear edge only");
    set_en(32'h0, 32'h0000_0008);
    rd(73, d); check("R11 enable clear", d, m_en);
    lines("R11 lines after disable");

    for (int i = 0; i < 32; i++)
      cfg(i, 3'($urandom), 2'($urandom), $urandom);
    set_en($urandom, 32'h0);
    lines("R2 after reconfig");
    for (int n = 0; n < 500; n++) begin
      case ($urandom_range(0, 9))
        0, 1, 2: set_src(m_src ^ ($urandom & $urandom & $urandom));
        3, 4:    ivr_read("R5 R6 random vector");
        5:       eoi();
        6:       set_en($urandom & $urandom, $urandom & $urandom);
        7: begin
          d = $urandom & $urandom & $urandom;
          wr(71, d); m_frc = d & ~32'd1;
        end
        8: begin
          m_prot = ($urandom_range(0, 3) == 0);
          wr(70, {30'd0, m_gm, m_prot});
          if (m_prot) begin ivr_read("R8 random protect read"); ivr_write(); end
        end
        default: begin
          d = $urandom & $urandom;
          wr(67, d); m_pe = m_pe & ~d;
          m_gm = ($urandom_range(0, 3) == 0);
          wr(70, {30'd0, m_gm, m_prot});
          chk_state("R11 R10 random state");
        end
      endcase
      lines("R4 R9 random lines");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule